// File: doc/BRIEF.md
# Byte-to-Word Write Packer

This block turns a byte-granular write request into a series of aligned word writes for a downstream word-program engine. A request carries a byte start address and a byte count. Data bytes arrive one at a time over a valid/ready stream. Words are packed big-endian: the byte at the lowest address sits in the most significant lane.

A word may be only partly covered by the request. This happens at the start of the range, at its end, or when the whole range fits inside one word. For such a word, the packer first reads the current contents of that word through a one-word read port. The lanes outside the range are then refilled with the old bytes, so the program engine always receives a complete word. A word fully covered by the request is built from the stream alone and causes no read.

Words go out one at a time. Each word waits for the engine's completion and its result code. The first nonzero result ends the request and is passed on as the request's result; no further words are written and no further stream bytes are taken. When all words complete with a zero result, the request ends in success.

Top module: `byte_word_packer`

## Requirements
- R1: The first word address is the start address with its low log2(BPW) bits (two bits at the default BPW=4) forced to zero. Each later word address is the previous one plus BPW. Every address on the write port is word aligned.
- R2: Each word is assembled in byte order with the earliest byte in bits 31:24 and the latest in bits 7:0 (default 32-bit words).
- R3: For an unaligned start, the lanes below the start offset in the first word carry the existing memory bytes of those lanes. Stream bytes follow them.
- R4: When the count runs out inside the first word, the remaining higher lanes of that word carry the existing memory bytes.
- R5: A word covered entirely by the request is built from stream bytes only and triggers no memory read.
- R6: A trailing partial word takes the remaining stream bytes in its low-address lanes and fills the rest from existing memory.
- R7: The first nonzero write result ends the request with that code on `done_result`. No later word is written and no further stream byte is accepted.
- R8: A request of length zero at an aligned address raises `done` on the second cycle after acceptance, with result 0, without any read or write.
- R9: A request of length zero at an unaligned address reads the addressed word once and writes it back unchanged as one word.
- R10: When every word completes with result 0, `done_result` is 0.
- R11: While `wr_valid` is high and `wr_done` has not been seen, `wr_addr` and `wr_data` hold steady.
- R12: `byt_ready` is high only while the packer needs a stream byte. Exactly the requested number of bytes is consumed on success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Packer idle, accepts a request |
| req_addr | input | AW | Byte start address |
| req_len | input | LW | Byte count |
| byt_valid | input | 1 | Stream byte offered |
| byt_ready | output | 1 | Stream byte taken this cycle when valid |
| byt_data | input | 8 | Stream byte |
| rd_req | output | 1 | Read of existing word, held until acknowledged |
| rd_addr | output | AW | Aligned word address to read |
| rd_ack | input | 1 | Read complete, data valid |
| rd_data | input | 8*BPW | Existing word contents |
| wr_valid | output | 1 | Word write request, held until done |
| wr_addr | output | AW | Aligned word address |
| wr_data | output | 8*BPW | Packed word |
| wr_done | input | 1 | Word write complete |
| wr_result | input | RW | Write result, zero means success |
| done | output | 1 | One-cycle request completion pulse |
| done_result | output | RW | Request result |

## Verification
The hardest case to reach is a write failure that lands in the middle of a multi-word transfer while stream bytes are still waiting. It must be shown that the packer then leaves the rest of the stream untouched. The bench's program-engine model returns a chosen nonzero code on a chosen write index. Its byte source keeps offering data at all times, so any stray consumption shows up in the count of bytes taken. Merged words are reached by unaligned starts and short counts, including a zero-length unaligned request. Each of these is compared with a memory image that gives every lane a distinct byte value.

// File: rtl/bwp_pkg.sv
package bwp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PLAN,
      ST_FETCH,
      ST_FILL,
      ST_WRITE,
      ST_DONE
   } bwp_state_e;
endpackage

// File: rtl/bwp_lane_plan.sv
// Per-word lane split: how many leading lanes come from memory, how many
// stream bytes follow, whether a read is needed, whether the request is over.
module bwp_lane_plan #(
   parameter int BPW = 4,
   parameter int LW  = 16,
   localparam int OFFW = $clog2(BPW),
   localparam int CW   = OFFW + 1
) (
   input  logic            first,
   input  logic [OFFW-1:0] off,
   input  logic [LW-1:0]   rem,
   output logic [CW-1:0]   lead,
   output logic [CW-1:0]   take,
   output logic            need_mem,
   output logic            finish
);
   logic [CW-1:0] avail;

   always_comb begin
      lead     = first ? {1'b0, off} : '0;
      avail    = CW'(BPW) - lead;
      take     = (rem < LW'(avail)) ? CW'(rem) : avail;
      need_mem = (lead != '0) || (take != avail);
      finish   = (rem == '0) && (lead == '0);
   end
endmodule

// File: rtl/bwp_word_asm.sv
// Shift-left word assembler; each step appends one byte taken either from
// the stream or from the matching lane of the fetched memory word.
module bwp_word_asm #(
   parameter int BPW = 4,
   localparam int DW   = 8 * BPW,
   localparam int OFFW = $clog2(BPW)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            step,
   input  logic            use_mem,
   input  logic [OFFW-1:0] lane_sel,
   input  logic [7:0]      stream_byte,
   input  logic [DW-1:0]   mem_word,
   output logic [DW-1:0]   word
);
   logic [7:0] lanes [BPW];
   logic [7:0] pick;

   for (genvar g = 0; g < BPW; g++) begin : g_lane
      assign lanes[g] = mem_word[DW-1-8*g -: 8];
   end

   assign pick = use_mem ? lanes[lane_sel] : stream_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     word <= '0;
      else if (clear) word <= '0;
      else if (step)  word <= {word[DW-9:0], pick};
   end
endmodule

// File: rtl/byte_word_packer.sv
module byte_word_packer #(
   parameter int AW  = 32,
   parameter int LW  = 16,
   parameter int BPW = 4,
   parameter int RW  = 2,
   localparam int DW = 8 * BPW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_addr,
   input  logic [LW-1:0] req_len,
   input  logic          byt_valid,
   output logic          byt_ready,
   input  logic [7:0]    byt_data,
   output logic          rd_req,
   output logic [AW-1:0] rd_addr,
   input  logic          rd_ack,
   input  logic [DW-1:0] rd_data,
   output logic          wr_valid,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   input  logic          wr_done,
   input  logic [RW-1:0] wr_result,
   output logic          done,
   output logic [RW-1:0] done_result
);
   import bwp_pkg::*;

   localparam int OFFW = $clog2(BPW);
   localparam int CW   = OFFW + 1;
   localparam logic [AW-1:0] ALIGN_MASK = ~AW'(BPW - 1);

   // elaboration-time parameter checks
   if (BPW < 2 || (1 << OFFW) != BPW) begin : g_bad_bpw
      $error("BPW must be a power of two of at least 2");
   end
   if (LW < CW) begin : g_bad_lw
      $error("LW too narrow for the lane count");
   end
   if (RW < 1) begin : g_bad_rw
      $error("RW must be at least 1");
   end

   bwp_state_e      state_q;
   logic [AW-1:0]   wa_q;
   logic [LW-1:0]   rem_q;
   logic [OFFW-1:0] off_q;
   logic            first_q;
   logic [CW-1:0]   lead_q, take_q;
   logic [OFFW-1:0] k_q;
   logic [DW-1:0]   mem_q;
   logic [RW-1:0]   res_q;

   logic [CW-1:0]   lead_w, take_w;
   logic            need_mem_w, finish_w;
   logic            in_stream, step, last_lane;
   logic [DW-1:0]   word_w;

   bwp_lane_plan #(.BPW(BPW), .LW(LW)) u_plan (
      .first    (first_q),
      .off      (off_q),
      .rem      (rem_q),
      .lead     (lead_w),
      .take     (take_w),
      .need_mem (need_mem_w),
      .finish   (finish_w)
   );

   assign in_stream = (state_q == ST_FILL) &&
                      (CW'(k_q) >= lead_q) && (CW'(k_q) < lead_q + take_q);
   assign step      = (state_q == ST_FILL) && (!in_stream || byt_valid);
   assign last_lane = (k_q == OFFW'(BPW - 1));

   bwp_word_asm #(.BPW(BPW)) u_asm (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (state_q == ST_PLAN),
      .step        (step),
      .use_mem     (!in_stream),
      .lane_sel    (k_q),
      .stream_byte (byt_data),
      .mem_word    (mem_q),
      .word        (word_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         wa_q    <= '0;
         rem_q   <= '0;
         off_q   <= '0;
         first_q <= 1'b0;
         lead_q  <= '0;
         take_q  <= '0;
         k_q     <= '0;
         mem_q   <= '0;
         res_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (req_valid) begin
               wa_q    <= req_addr & ALIGN_MASK;
               off_q   <= req_addr[OFFW-1:0];
               rem_q   <= req_len;
               first_q <= 1'b1;
               state_q <= ST_PLAN;
            end
            ST_PLAN: begin
               if (finish_w) begin
                  res_q   <= '0;
                  state_q <= ST_DONE;
               end else begin
                  lead_q  <= lead_w;
                  take_q  <= take_w;
                  k_q     <= '0;
                  state_q <= need_mem_w ? ST_FETCH : ST_FILL;
               end
            end
            ST_FETCH: if (rd_ack) begin
               mem_q   <= rd_data;
               state_q <= ST_FILL;
            end
            ST_FILL: if (step) begin
               k_q <= k_q + 1'b1;
               if (in_stream) rem_q <= rem_q - 1'b1;
               if (last_lane) state_q <= ST_WRITE;
            end
            ST_WRITE: if (wr_done) begin
               if (wr_result != '0) begin
                  res_q   <= wr_result;
                  state_q <= ST_DONE;
               end else begin
                  wa_q    <= wa_q + AW'(BPW);
                  first_q <= 1'b0;
                  state_q <= ST_PLAN;
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready   = (state_q == ST_IDLE);
   assign byt_ready   = in_stream;
   assign rd_req      = (state_q == ST_FETCH);
   assign rd_addr     = wa_q;
   assign wr_valid    = (state_q == ST_WRITE);
   assign wr_addr     = wa_q;
   assign wr_data     = word_w;
   assign done        = (state_q == ST_DONE);
   assign done_result = res_q;

   // ---------------- assertions ----------------
   logic [AW-1:0] prev_wa;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   prev_wa <= '0;
      else if (wr_valid && wr_done) prev_wa <= wr_addr;
   end

   p_aligned_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (wr_addr[OFFW-1:0] == '0));

   p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(wr_valid) && !first_q) |-> (wr_addr == prev_wa + AW'(BPW)));

   p_hold_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_done) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

   p_stop_on_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_done && (wr_result != '0)) |=>
         (done && (done_result == $past(wr_result))));

   p_zero_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && (req_len == '0) && (req_addr[OFFW-1:0] == '0)) |=>
         (!wr_valid && !rd_req) ##1 (done && (done_result == '0)));

   p_no_byte_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !byt_ready);
endmodule

// File: tb/test_byte_word_packer.sv
module test_byte_word_packer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [15:0] req_len = '0;
   logic        byt_valid = 1'b0;
   logic        byt_ready;
   logic [7:0]  byt_data = '0;
   logic        rd_req;
   logic [31:0] rd_addr;
   logic        rd_ack = 1'b0;
   logic [31:0] rd_data = '0;
   logic        wr_valid;
   logic [31:0] wr_addr;
   logic [31:0] wr_data;
   logic        wr_done = 1'b0;
   logic [1:0]  wr_result = '0;
   logic        done;
   logic [1:0]  done_result;

   always #5 clk = ~clk;

   byte_word_packer i_byte_word_packer (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
      .byt_valid(byt_valid), .byt_ready(byt_ready), .byt_data(byt_data),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_done(wr_done), .wr_result(wr_result),
      .done(done), .done_result(done_result)
   );

   int n_chk = 0;
   int n_fail = 0;

   logic [7:0]  src [0:15];
   logic [31:0] mem [0:7];
   logic [31:0] wlog_a [0:7];
   logic [31:0] wlog_d [0:7];
   int src_n = 0, idx = 0, wcnt = 0, rcnt = 0, wdly = 0;
   int fail_at = 99;
   logic [1:0] fail_code = '0;
   logic rdy_s = 1'b0;
   logic done_seen = 1'b0;
   logic [1:0] done_res = '0;
   int cyc = 0, done_cyc = 0, hold_err = 0;
   logic prev_wv = 1'b0, prev_done = 1'b0;
   logic [31:0] ha = '0, hd = '0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // responders: sample outputs and drive inputs on the falling edge
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         // byte source
         if (byt_valid && rdy_s) idx++;
         rdy_s = byt_ready;
         byt_valid = (idx < src_n);
         byt_data  = (idx < src_n) ? src[idx] : 8'h00;
         // existing-memory read port
         if (rd_ack) rd_ack = 1'b0;
         else if (rd_req) begin
            rd_ack  = 1'b1;
            rd_data = mem[rd_addr[4:2]];
            rcnt++;
         end
         // hold check for the write port
         if (wr_valid && prev_wv && !prev_done && (wr_addr !== ha || wr_data !== hd))
            hold_err++;
         // program engine
         if (wr_done) wr_done = 1'b0;
         else if (wr_valid) begin
            wdly++;
            if (wdly == 2) begin
               if (wcnt < 8) begin
                  wlog_a[wcnt] = wr_addr;
                  wlog_d[wcnt] = wr_data;
               end
               wr_done   = 1'b1;
               wr_result = (wcnt == fail_at) ? fail_code : 2'd0;
               wcnt++;
               wdly = 0;
            end
         end
         prev_wv = wr_valid; prev_done = wr_done; ha = wr_addr; hd = wr_data;
         if (done && !done_seen) begin
            done_seen = 1'b1;
            done_res  = done_result;
            done_cyc  = cyc;
         end
      end
   end

   task automatic run(input int addr, input int len, input int fa, input logic [1:0] code,
                      input string dtag, input logic [7:0] seed);
      int wp, off, nw, ew, er, ec, acc;
      logic [31:0] ed [0:7];
      logic [1:0]  eres;
      wp  = addr & ~3;
      off = addr & 3;
      nw  = (len == 0 && off == 0) ? 0 : (off + len + 3) / 4;
      ew  = (fa < nw) ? fa + 1 : nw;
      er  = 0;
      for (int i = 0; i < 16; i++) src[i] = 8'(seed + 8'(i * 17));
      for (int w = 0; w < ew; w++) begin
         logic usem;
         usem  = 1'b0;
         ed[w] = '0;
         for (int b = 0; b < 4; b++) begin
            int a;
            logic [7:0] by;
            a = wp + 4 * w + b;
            if (a >= addr && a < addr + len) by = src[a - addr];
            else begin
               by   = mem[a >> 2][31 - 8 * (a & 3) -: 8];
               usem = 1'b1;
            end
            ed[w] = {ed[w][23:0], by};
         end
         if (usem) er++;
      end
      ec = (wp + 4 * ew) - addr;
      if (ec > len) ec = len;
      if (ec < 0) ec = 0;
      eres = (fa < nw) ? code : 2'd0;

      @(negedge clk); #1;
      idx = 0; src_n = len; wcnt = 0; rcnt = 0; wdly = 0;
      fail_at = fa; fail_code = code; done_seen = 1'b0;
      req_valid = 1'b1; req_addr = 32'(addr); req_len = 16'(len); acc = cyc;
      @(negedge clk); #1;
      req_valid = 1'b0;
      for (int t = 0; t < 500 && !done_seen; t++) @(negedge clk);
      #1;
      chk("R10 watchdog: done seen", 32'(done_seen), 32'd1);
      repeat (3) @(negedge clk);
      #1;
      chk("R1 write count", 32'(wcnt), 32'(ew));
      for (int w = 0; w < ew && w < wcnt; w++) begin
         chk("R1 word address", wlog_a[w], 32'(wp + 4 * w));
         chk(dtag, wlog_d[w], ed[w]);
      end
      chk("R5 memory read count", 32'(rcnt), 32'(er));
      chk("R12 stream bytes consumed", 32'(idx), 32'(ec));
      chk((fa < nw) ? "R7 result code" : "R10 result code", 32'(done_res), 32'(eres));
      if (len == 0 && off == 0) chk("R8 completion latency", 32'(done_cyc - acc), 32'd2);
   endtask

   task automatic t_reset();
      chk("R12 req_ready after reset", 32'(req_ready), 32'd1);
      chk("R12 byt_ready after reset", 32'(byt_ready), 32'd0);
      chk("R11 wr_valid after reset", 32'(wr_valid), 32'd0);
      chk("R5 rd_req after reset", 32'(rd_req), 32'd0);
      chk("R10 done after reset", 32'(done), 32'd0);
   endtask

   task automatic t_aligned_full();   run(32'h08, 8, 99, 2'd0, "R2 aligned full words", 8'h11); endtask
   task automatic t_inside_first();   run(32'h05, 2, 99, 2'd0, "R4 short run inside first word", 8'h22); endtask
   task automatic t_lead_and_tail();  run(32'h0E, 9, 99, 2'd0, "R6 leading and trailing merge", 8'h33); endtask
   task automatic t_lead_only();      run(32'h11, 7, 99, 2'd0, "R3 unaligned start", 8'h44); endtask
   task automatic t_zero_aligned();   run(32'h10, 0, 99, 2'd0, "R8 zero length", 8'h55); endtask
   task automatic t_zero_unaligned(); run(32'h13, 0, 99, 2'd0, "R9 zero length unaligned", 8'h66); endtask
   task automatic t_fail_middle();    run(32'h00, 12, 1, 2'd2, "R7 fail on second word", 8'h77); endtask
   task automatic t_fail_first();     run(32'h06, 10, 0, 2'd1, "R7 fail on first word", 8'h88); endtask

   initial begin
      for (int i = 0; i < 8; i++)
         mem[i] = {8'(8'h40 + 4 * i), 8'(8'h41 + 4 * i), 8'(8'h42 + 4 * i), 8'(8'h43 + 4 * i)};
      repeat (3) @(negedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      t_aligned_full();
      t_inside_first();
      t_lead_and_tail();
      t_lead_only();
      t_zero_aligned();
      t_zero_unaligned();
      t_fail_middle();
      t_fail_first();
      t_aligned_full();
      chk("R11 write port held while pending", 32'(hold_err), 32'd0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1500000;
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule